// File: doc/BRIEF.md
# Montgomery Ladder Point Multiplier

This block computes the scalar multiple kP of a point P on a binary-field elliptic curve of the form y^2 + xy = x^3 + ax^2 + b. It works only on x and z projective coordinates, so no field inversion is needed inside the loop. The caller supplies the affine x coordinate of P, the curve constant b and an N-bit scalar, then pulses `start`. The block returns two projective pairs: (X1,Z1) stands for kP and (X2,Z2) stands for (k+1)P. Converting them back to affine form is left to a later stage.

Every general field product goes to a multiplier outside the block. The block reaches it through a request/acknowledge handshake, which lets several engines share one multiplier. Squaring is done by dedicated combinational squarers, and field addition is a bitwise XOR. Each ladder iteration needs six products. The current scalar bit decides which pair receives the differential add and which pair is doubled. Both new pairs are built from the values held at the start of the iteration and are written back in the same cycle.

The field width M, the reduction polynomial and the scalar width N are parameters.

Top module: `ladder_pmul`

## Requirements
- R1: While reset is held and after it is released, `done` and `mul_req` are 0 and all four coordinate outputs are 0.
- R2: An accepted start loads X1 = x, Z1 = 1 (the field element whose only set bit is bit 0), X2 = x^4 XOR b and Z2 = x^2. These values appear on the outputs in the cycle after `start`.
- R3: With N = 1 there is no loop. `done` pulses in the cycle after `start`, the outputs hold the loaded values of R2, and `mul_req` never rises.
- R4: For N > 1, bits N-2 down to 0 of the scalar are consumed in that order. When a bit is 1, (X1,Z1) receives the add and (X2,Z2) is doubled. When a bit is 0, the roles are swapped.
- R5: The add into pair (A,Az), using the other pair (D,Dz), gives Az' = (A·Dz + D·Az)^2 and A' = x·Az' + (A·Dz)·(D·Az). The double of (D,Dz) gives Dz' = D^2·Dz^2 and D' = D^4 + b·Dz^4. Every operand is a value held at the start of the iteration.
- R6: At `done`, X1 = x(kP)·Z1 and X2 = x((k+1)P)·Z2. If a multiple is the point at infinity, its Z is 0.
- R7: `mul_req` is high exactly while a run is in progress. While it waits for `mul_ack`, `mul_a` and `mul_b` hold steady. A run makes exactly 6·(N-1) transfers, and `mul_res` is taken in the cycle where `mul_ack` is high.
- R8: `done` is high for a single cycle, in the cycle after the final transfer of a run.
- R9: A `start` that arrives during a run has no effect on the run or its results.
- R10: After `done`, the outputs stay unchanged until the next accepted start, whatever the other inputs do.
- R11: The top scalar bit k[N-1] is treated as 1 whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run when the block is idle |
| x_in | input | M | Affine x coordinate of the base point |
| b_in | input | M | Curve constant b |
| k_in | input | N | Scalar, most significant bit taken as 1 |
| mul_req | output | 1 | Product request to the shared multiplier |
| mul_a | output | M | First multiplier operand |
| mul_b | output | M | Second multiplier operand |
| mul_ack | input | 1 | Multiplier accepts the request and returns the product |
| mul_res | input | M | Product, valid while mul_ack is high |
| done | output | 1 | One-cycle end-of-run pulse |
| x1_out | output | M | Projective X of kP |
| z1_out | output | M | Projective Z of kP |
| x2_out | output | M | Projective X of (k+1)P |
| z2_out | output | M | Projective Z of (k+1)P |

## Verification
The assertions assume that `mul_ack` rises only while `mul_req` is high, with `mul_res` already holding the product of the operands shown. The bench's multiplier model answers only an open request, computes the product in the same cycle and inserts a random wait of zero to three cycles. The affine cross-check also assumes that x is nonzero, b is nonzero and P lies on the curve. The bench finds such points by searching the small field, so every base point it drives meets these conditions.

// File: rtl/ladder_pkg.sv
package ladder_pkg;
   // Micro-operation order within one ladder iteration (one product each).
   typedef enum logic [2:0] {
      OP_T1 = 3'd0,  // added-pair X times doubled-pair Z
      OP_T2 = 3'd1,  // doubled-pair X times added-pair Z
      OP_XS = 3'd2,  // base x times squared sum
      OP_TT = 3'd3,  // cross product of the two partial terms
      OP_DZ = 3'd4,  // doubled X^2 times doubled Z^2
      OP_BZ = 3'd5   // curve b times doubled Z^4
   } op_e;

   localparam int NUM_OPS = 6;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_e;
endpackage

// File: rtl/gf_sqr.sv
module gf_sqr #(
   parameter int          M    = 7,
   parameter logic [M-1:0] POLY = 7'h03
) (
   input  logic [M-1:0] a,
   output logic [M-1:0] y
);
   localparam int W = 2 * M - 1;

   logic [W-1:0] spread;

   // Squaring in GF(2^M) interleaves zeros between the operand bits.
   generate
      for (genvar i = 0; i < M; i++) begin : g_spread
         assign spread[2*i] = a[i];
         if (i < M - 1) begin : g_gap
            assign spread[2*i+1] = 1'b0;
         end
      end
   endgenerate

   // Fold the high half back with x^M == POLY, top term first.
   always_comb begin
      logic [W-1:0] acc;
      acc = spread;
      for (int j = W - 1; j >= M; j--) begin
         if (acc[j]) begin
            acc[j]         = 1'b0;
            acc[j-M +: M]  = acc[j-M +: M] ^ POLY;
         end
      end
      y = acc[M-1:0];
   end
endmodule

// File: rtl/ladder_seq.sv
module ladder_seq
   import ladder_pkg::*;
#(
   parameter int N  = 8,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic          xfer,
   output logic          busy,
   output op_e           op,
   output logic [IW-1:0] idx,
   output logic          wb,
   output logic          fin
);
   localparam int            IDX_INIT = (N > 1) ? N - 2 : 0;
   localparam logic [IW-1:0] IDX_LOAD = IW'(IDX_INIT);
   localparam op_e           OP_LAST  = op_e'(NUM_OPS - 1);

   seq_e          st_q;
   op_e           op_q;
   logic [IW-1:0] idx_q;

   assign busy = (st_q == SEQ_RUN);
   assign op   = op_q;
   assign idx  = idx_q;
   assign wb   = busy && xfer && (op_q == OP_LAST);
   assign fin  = wb && (idx_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SEQ_IDLE;
         op_q  <= OP_T1;
         idx_q <= '0;
      end else if (!busy) begin
         if (launch && (N > 1)) begin
            st_q  <= SEQ_RUN;
            op_q  <= OP_T1;
            idx_q <= IDX_LOAD;
         end
      end else if (xfer) begin
         if (op_q == OP_LAST) begin
            op_q <= OP_T1;
            if (idx_q == '0) begin
               st_q <= SEQ_IDLE;
            end else begin
               idx_q <= idx_q - IW'(1);
            end
         end else begin
            op_q <= op_e'(op_q + 3'd1);
         end
      end
   end
endmodule

// File: rtl/ladder_pmul.sv
module ladder_pmul
   import ladder_pkg::*;
#(
   parameter int           M    = 7,
   parameter int           N    = 8,
   parameter logic [M-1:0] POLY = 7'h03
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [M-1:0] x_in,
   input  logic [M-1:0] b_in,
   input  logic [N-1:0] k_in,
   output logic         mul_req,
   output logic [M-1:0] mul_a,
   output logic [M-1:0] mul_b,
   input  logic         mul_ack,
   input  logic [M-1:0] mul_res,
   output logic         done,
   output logic [M-1:0] x1_out,
   output logic [M-1:0] z1_out,
   output logic [M-1:0] x2_out,
   output logic [M-1:0] z2_out
);
   localparam int           IW  = (N > 1) ? $clog2(N) : 1;
   localparam logic [M-1:0] ONE = M'(1);

   // Elaboration-time parameter checks
   generate
      if (M < 2) begin : g_bad_m
         $error("ladder_pmul: field width M must be at least 2");
      end
      if (N < 1) begin : g_bad_n
         $error("ladder_pmul: scalar width N must be at least 1");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("ladder_pmul: reduction polynomial needs a constant term");
      end
   endgenerate

   // Sequencer
   logic          busy, wb, fin, launch, xfer;
   op_e           op;
   logic [IW-1:0] idx;

   assign launch = start && !busy;
   assign xfer   = busy && mul_ack;

   ladder_seq #(.N(N), .IW(IW)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .xfer   (xfer),
      .busy   (busy),
      .op     (op),
      .idx    (idx),
      .wb     (wb),
      .fin    (fin)
   );

   // Architectural state
   logic [M-1:0] xr, br;
   logic [N-1:0] kr;
   logic [M-1:0] x1_q, z1_q, x2_q, z2_q;
   logic [M-1:0] t1_q, t2_q, u_q, v_q, dz_q;
   logic         done_q;

   // Role selection by the current scalar bit
   logic         kb;
   logic [M-1:0] add_x, add_z, dbl_x, dbl_z;

   assign kb    = kr[idx];
   assign add_x = kb ? x1_q : x2_q;
   assign add_z = kb ? z1_q : z2_q;
   assign dbl_x = kb ? x2_q : x1_q;
   assign dbl_z = kb ? z2_q : z1_q;

   // Dedicated squarers
   logic [M-1:0] sum_t, sq_sum, dx2, dz2, dx4, dz4, ix2, ix4;

   assign sum_t = t1_q ^ t2_q;

   gf_sqr #(.M(M), .POLY(POLY)) u_sq_sum (.a(sum_t), .y(sq_sum));
   gf_sqr #(.M(M), .POLY(POLY)) u_sq_dx2 (.a(dbl_x), .y(dx2));
   gf_sqr #(.M(M), .POLY(POLY)) u_sq_dz2 (.a(dbl_z), .y(dz2));
   gf_sqr #(.M(M), .POLY(POLY)) u_sq_dx4 (.a(dx2),   .y(dx4));
   gf_sqr #(.M(M), .POLY(POLY)) u_sq_dz4 (.a(dz2),   .y(dz4));
   gf_sqr #(.M(M), .POLY(POLY)) u_sq_ix2 (.a(x_in),  .y(ix2));
   gf_sqr #(.M(M), .POLY(POLY)) u_sq_ix4 (.a(ix2),   .y(ix4));

   // Multiplier operand routing per micro-operation
   always_comb begin
      unique case (op)
         OP_T1:   begin mul_a = add_x; mul_b = dbl_z;  end
         OP_T2:   begin mul_a = dbl_x; mul_b = add_z;  end
         OP_XS:   begin mul_a = xr;    mul_b = sq_sum; end
         OP_TT:   begin mul_a = t1_q;  mul_b = t2_q;   end
         OP_DZ:   begin mul_a = dx2;   mul_b = dz2;    end
         OP_BZ:   begin mul_a = br;    mul_b = dz4;    end
         default: begin mul_a = '0;    mul_b = '0;     end
      endcase
   end

   assign mul_req = busy;

   // New pair values at the end of an iteration
   logic [M-1:0] add_x_n, add_z_n, dbl_x_n, dbl_z_n;

   assign add_z_n = sq_sum;
   assign add_x_n = u_q ^ v_q;
   assign dbl_z_n = dz_q;
   assign dbl_x_n = dx4 ^ mul_res;

   // Partial products
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t1_q <= '0;
         t2_q <= '0;
         u_q  <= '0;
         v_q  <= '0;
         dz_q <= '0;
      end else if (xfer) begin
         unique case (op)
            OP_T1:   t1_q <= mul_res;
            OP_T2:   t2_q <= mul_res;
            OP_XS:   u_q  <= mul_res;
            OP_TT:   v_q  <= mul_res;
            OP_DZ:   dz_q <= mul_res;
            default: ;
         endcase
      end
   end

   // Operand latches and coordinate pairs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xr   <= '0;
         br   <= '0;
         kr   <= '0;
         x1_q <= '0;
         z1_q <= '0;
         x2_q <= '0;
         z2_q <= '0;
      end else if (launch) begin
         xr   <= x_in;
         br   <= b_in;
         kr   <= k_in;
         x1_q <= x_in;
         z1_q <= ONE;
         x2_q <= ix4 ^ b_in;
         z2_q <= ix2;
      end else if (wb) begin
         if (kb) begin
            x1_q <= add_x_n;
            z1_q <= add_z_n;
            x2_q <= dbl_x_n;
            z2_q <= dbl_z_n;
         end else begin
            x2_q <= add_x_n;
            z2_q <= add_z_n;
            x1_q <= dbl_x_n;
            z1_q <= dbl_z_n;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else begin
         done_q <= fin || (launch && (N == 1));
      end
   end

   assign done   = done_q;
   assign x1_out = x1_q;
   assign z1_out = z1_q;
   assign x2_out = x2_q;
   assign z2_out = z2_q;
endmodule

// File: rtl/ladder_pmul_chk.sv
module ladder_pmul_chk #(
   parameter int M = 7,
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [M-1:0] x_in,
   input logic         mul_req,
   input logic         mul_ack,
   input logic [M-1:0] mul_a,
   input logic [M-1:0] mul_b,
   input logic         done,
   input logic [M-1:0] x1_out,
   input logic [M-1:0] z1_out,
   input logic [M-1:0] x2_out,
   input logic [M-1:0] z2_out
);
   localparam logic [M-1:0] ONE = M'(1);

   // R2: an accepted start loads the base point into the first pair
   p_init_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !mul_req) |=> (x1_out == $past(x_in)) && (z1_out == ONE));

   // R7: an open request keeps its operands until acknowledged
   p_req_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_req && !mul_ack) |=> mul_req && $stable(mul_a) && $stable(mul_b));

   // R9: a start during a run neither ends nor reloads it
   p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mul_req && !mul_ack) |=> mul_req && $stable(x1_out) && $stable(z1_out)
                                        && $stable(x2_out) && $stable(z2_out));

   // R10: outputs move only on a load or a product transfer
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !(mul_req && mul_ack)) |=> $stable(x1_out) && $stable(z1_out)
                                           && $stable(x2_out) && $stable(z2_out));

   generate
      if (N > 1) begin : g_loop
         // R8: single-cycle completion pulse
         p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            done |=> !done);
         // R8: completion follows a product transfer
         p_done_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> $past(mul_req && mul_ack));
      end else begin : g_flat
         // R3: no loop, immediate completion
         p_flat_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> done);
         // R3: the multiplier is never requested
         p_flat_noreq_r3: assert property (@(posedge clk) disable iff (!rst_n)
            mul_req == 1'b0);
      end
   endgenerate
endmodule

bind ladder_pmul ladder_pmul_chk #(.M(M), .N(N)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .x_in    (x_in),
   .mul_req (mul_req),
   .mul_ack (mul_ack),
   .mul_a   (mul_a),
   .mul_b   (mul_b),
   .done    (done),
   .x1_out  (x1_out),
   .z1_out  (z1_out),
   .x2_out  (x2_out),
   .z2_out  (z2_out)
);

// File: tb/tb_ladder_pmul.sv
`timescale 1ns/1ps
module tb_ladder_pmul;
   localparam int           M     = 7;
   localparam int           N     = 8;
   localparam logic [M-1:0] POLY  = 7'h03;
   localparam logic [M-1:0] ONE   = 7'd1;
   localparam logic [M-1:0] ACOEF = 7'd1;
   localparam int           TOTAL = 6 * (N - 1);
   localparam int           FSZ   = 1 << M;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         start1 = 1'b0;
   logic [M-1:0] x_in = '0;
   logic [M-1:0] b_in = '0;
   logic [N-1:0] k_in = '0;
   logic         mul_req, mul_ack;
   logic [M-1:0] mul_a, mul_b, mul_res;
   logic         done;
   logic [M-1:0] x1_out, z1_out, x2_out, z2_out;

   logic         req1, done1;
   logic [M-1:0] a1, b1;
   logic [M-1:0] x1o, z1o, x2o, z2o;

   always #4 clk = ~clk;   // 125 MHz

   ladder_pmul #(.M(M), .N(N), .POLY(POLY)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .b_in(b_in), .k_in(k_in),
      .mul_req(mul_req), .mul_a(mul_a), .mul_b(mul_b), .mul_ack(mul_ack), .mul_res(mul_res),
      .done(done), .x1_out(x1_out), .z1_out(z1_out), .x2_out(x2_out), .z2_out(z2_out));

   ladder_pmul #(.M(M), .N(1), .POLY(POLY)) dut1 (
      .clk(clk), .rst_n(rst_n), .start(start1), .x_in(x_in), .b_in(b_in), .k_in(1'b1),
      .mul_req(req1), .mul_a(a1), .mul_b(b1), .mul_ack(1'b0), .mul_res('0),
      .done(done1), .x1_out(x1o), .z1_out(z1o), .x2_out(x2o), .z2_out(z2o));

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- field arithmetic ----------------
   function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
      logic [M-1:0] r;
      r = '0;
      for (int i = M - 1; i >= 0; i--) begin
         r = r[M-1] ? ({r[M-2:0], 1'b0} ^ POLY) : {r[M-2:0], 1'b0};
         if (b[i]) r = r ^ a;
      end
      return r;
   endfunction

   function automatic logic [M-1:0] gsq(input logic [M-1:0] a);
      return gmul(a, a);
   endfunction

   function automatic logic [M-1:0] ginv(input logic [M-1:0] a);
      logic [M-1:0] s, r;
      s = a;
      r = ONE;
      for (int i = 1; i < M; i++) begin
         s = gsq(s);
         r = gmul(r, s);
      end
      return r;
   endfunction

   // ---------------- projective ladder (spec formulas) ----------------
   task automatic ladder_ref(input logic [M-1:0] bx, input logic [M-1:0] bb,
                             input logic [N-1:0] kk,
                             output logic [M-1:0] ox1, output logic [M-1:0] oz1,
                             output logic [M-1:0] ox2, output logic [M-1:0] oz2);
      logic [M-1:0] p1x, p1z, p2x, p2z, ax, az, dx, dz, t1, t2, nz;
      p1x = bx;
      p1z = ONE;
      p2x = gsq(gsq(bx)) ^ bb;
      p2z = gsq(bx);
      for (int i = N - 2; i >= 0; i--) begin
         if (kk[i]) begin ax = p1x; az = p1z; dx = p2x; dz = p2z; end
         else       begin ax = p2x; az = p2z; dx = p1x; dz = p1z; end
         t1 = gmul(ax, dz);
         t2 = gmul(dx, az);
         nz = gsq(t1 ^ t2);
         ax = gmul(bx, nz) ^ gmul(t1, t2);
         az = nz;
         nz = gmul(gsq(dx), gsq(dz));
         dx = gsq(gsq(dx)) ^ gmul(bb, gsq(gsq(dz)));
         dz = nz;
         if (kk[i]) begin p1x = ax; p1z = az; p2x = dx; p2z = dz; end
         else       begin p2x = ax; p2z = az; p1x = dx; p1z = dz; end
      end
      ox1 = p1x; oz1 = p1z; ox2 = p2x; oz2 = p2z;
   endtask

   // ---------------- affine double-and-add ----------------
   task automatic aff_dbl(input logic [M-1:0] px, input logic [M-1:0] py, input bit pi,
                          output logic [M-1:0] rx, output logic [M-1:0] ry, output bit ri);
      logic [M-1:0] lam;
      if (pi || px == '0) begin
         rx = '0; ry = '0; ri = 1'b1;
      end else begin
         lam = px ^ gmul(py, ginv(px));
         rx  = gsq(lam) ^ lam ^ ACOEF;
         ry  = gsq(px) ^ gmul(lam ^ ONE, rx);
         ri  = 1'b0;
      end
   endtask

   task automatic aff_add(input logic [M-1:0] px, input logic [M-1:0] py, input bit pi,
                          input logic [M-1:0] qx, input logic [M-1:0] qy, input bit qi,
                          output logic [M-1:0] rx, output logic [M-1:0] ry, output bit ri);
      logic [M-1:0] lam;
      if (pi) begin
         rx = qx; ry = qy; ri = qi;
      end else if (qi) begin
         rx = px; ry = py; ri = pi;
      end else if (px == qx) begin
         if (py == qy) aff_dbl(px, py, 1'b0, rx, ry, ri);
         else begin rx = '0; ry = '0; ri = 1'b1; end
      end else begin
         lam = gmul(py ^ qy, ginv(px ^ qx));
         rx  = gsq(lam) ^ lam ^ px ^ qx ^ ACOEF;
         ry  = gmul(lam, px ^ rx) ^ rx ^ py;
         ri  = 1'b0;
      end
   endtask

   task automatic find_point(input logic [M-1:0] bb, input int seed,
                             output logic [M-1:0] px, output logic [M-1:0] py);
      bit found;
      found = 1'b0;
      px = ONE;
      py = '0;
      for (int s = 0; s < FSZ && !found; s++) begin
         logic [M-1:0] xx, rhs;
         xx = M'((seed + s) % (FSZ - 1) + 1);
         rhs = gmul(gsq(xx), xx) ^ gmul(ACOEF, gsq(xx)) ^ bb;
         for (int y = 0; y < FSZ && !found; y++) begin
            logic [M-1:0] yy;
            yy = M'(y);
            if ((gsq(yy) ^ gmul(xx, yy)) == rhs) begin
               px = xx; py = yy; found = 1'b1;
            end
         end
      end
   endtask

   // ---------------- multiplier model and per-cycle run model ----------------
   bit model_busy = 1'b0;
   bit exp_done   = 1'b0;
   int run_xfers  = 0;

   initial begin : responder
      int  wcnt;
      bit  launch, xfer;
      wcnt    = 0;
      mul_ack = 1'b0;
      mul_res = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            chk(done === exp_done, "R8", "done timing", int'(done), int'(exp_done));
            chk(mul_req === model_busy, "R7", "request only while running",
                int'(mul_req), int'(model_busy));
            chk(req1 === 1'b0, "R3", "flat variant request", int'(req1), 0);
         end
         launch = start && !model_busy && rst_n;
         if (mul_req && wcnt == 0) begin
            mul_ack = 1'b1;
         end else begin
            mul_ack = 1'b0;
            if (mul_req && wcnt > 0) wcnt--;
         end
         mul_res  = gmul(mul_a, mul_b);
         xfer     = mul_req && mul_ack;
         exp_done = 1'b0;
         if (xfer) begin
            run_xfers++;
            wcnt = $urandom % 4;
            if (run_xfers == TOTAL) begin
               exp_done   = 1'b1;
               model_busy = 1'b0;
            end
         end
         if (launch) begin
            model_busy = 1'b1;
            run_xfers  = 0;
         end
      end
   end

   // ---------------- one full run ----------------
   task automatic run_one(input logic [M-1:0] bx, input logic [M-1:0] bb,
                          input logic [N-1:0] kk, input logic [M-1:0] py, input bit poke);
      logic [M-1:0] ex1, ez1, ex2, ez2, qx, qy, rx, ry;
      logic [M-1:0] hx1, hz1, hx2, hz2;
      bit qi, ri;
      @(posedge clk); #2;
      x_in = bx; b_in = bb; k_in = kk; start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
      @(negedge clk);
      chk(x1_out == bx, "R2", "load X1", x1_out, bx);
      chk(z1_out == ONE, "R2", "load Z1", z1_out, ONE);
      chk(x2_out == (gsq(gsq(bx)) ^ bb), "R2", "load X2", x2_out, gsq(gsq(bx)) ^ bb);
      chk(z2_out == gsq(bx), "R2", "load Z2", z2_out, gsq(bx));
      if (poke) begin
         repeat (5) @(posedge clk);
         #2;
         x_in = bx ^ 7'h55; b_in = ~bb; k_in = ~kk; start = 1'b1;
         @(posedge clk); #2;
         start = 1'b0;
      end
      do @(negedge clk); while (!done);
      chk(run_xfers == TOTAL, "R7", "transfers per run", run_xfers, TOTAL);
      ladder_ref(bx, bb, kk, ex1, ez1, ex2, ez2);
      chk(x1_out == ex1, poke ? "R9" : "R4 R5", "final X1", x1_out, ex1);
      chk(z1_out == ez1, poke ? "R9" : "R4 R5", "final Z1", z1_out, ez1);
      chk(x2_out == ex2, poke ? "R9" : "R4 R5", "final X2", x2_out, ex2);
      chk(z2_out == ez2, poke ? "R9" : "R4 R5", "final Z2", z2_out, ez2);
      // Affine cross-check: top bit taken as 1 (R11)
      qx = bx; qy = py; qi = 1'b0;
      for (int i = N - 2; i >= 0; i--) begin
         aff_dbl(qx, qy, qi, rx, ry, ri);
         qx = rx; qy = ry; qi = ri;
         if (kk[i]) begin
            aff_add(qx, qy, qi, bx, py, 1'b0, rx, ry, ri);
            qx = rx; qy = ry; qi = ri;
         end
      end
      if (qi) chk(z1_out == '0, "R6", "kP at infinity, Z1", z1_out, 0);
      else    chk(z1_out != '0 && x1_out == gmul(qx, z1_out), "R6 R11", "x(kP) ratio",
                  x1_out, gmul(qx, z1_out));
      aff_add(qx, qy, qi, bx, py, 1'b0, rx, ry, ri);
      if (ri) chk(z2_out == '0, "R6", "(k+1)P at infinity, Z2", z2_out, 0);
      else    chk(z2_out != '0 && x2_out == gmul(rx, z2_out), "R6 R11", "x((k+1)P) ratio",
                  x2_out, gmul(rx, z2_out));
      // Hold: change inputs without a start
      hx1 = x1_out; hz1 = z1_out; hx2 = x2_out; hz2 = z2_out;
      @(posedge clk); #2;
      x_in = ~bx; b_in = bb ^ 7'h2A; k_in = kk ^ 8'h5C;
      repeat (4) @(negedge clk);
      chk(x1_out == hx1, "R10", "hold X1", x1_out, hx1);
      chk(z1_out == hz1, "R10", "hold Z1", z1_out, hz1);
      chk(x2_out == hx2, "R10", "hold X2", x2_out, hx2);
      chk(z2_out == hz2, "R10", "hold Z2", z2_out, hz2);
   endtask

   // ---------------- watchdog ----------------
   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin : main
      logic [M-1:0] px, py;
      logic [M-1:0] bvals [3];
      logic [N-1:0] kvals [6];
      bvals[0] = 7'h01; bvals[1] = 7'h35; bvals[2] = 7'h5A;
      kvals[0] = 8'h80; kvals[1] = 8'hFF; kvals[2] = 8'hA5;
      kvals[3] = 8'h81; kvals[4] = 8'hC3; kvals[5] = 8'hB6;

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0 && mul_req == 1'b0, "R1", "reset done/request",
          int'({done, mul_req}), 0);
      chk((x1_out | z1_out | x2_out | z2_out) == '0, "R1", "reset coordinates",
          x1_out | z1_out | x2_out | z2_out, 0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && mul_req == 1'b0, "R1", "after reset release",
          int'({done, mul_req}), 0);

      // R3: flat variant with a one-bit scalar
      find_point(bvals[1], 9, px, py);
      @(posedge clk); #2;
      x_in = px; b_in = bvals[1]; start1 = 1'b1;
      @(posedge clk); #2;
      start1 = 1'b0;
      @(negedge clk);
      chk(done1 == 1'b1, "R3", "flat done", int'(done1), 1);
      chk(x1o == px && z1o == ONE, "R3", "flat first pair", {x1o, z1o}, {px, ONE});
      chk(x2o == (gsq(gsq(px)) ^ bvals[1]) && z2o == gsq(px), "R3", "flat second pair",
          {x2o, z2o}, {gsq(gsq(px)) ^ bvals[1], gsq(px)});
      @(negedge clk);
      chk(done1 == 1'b0, "R3", "flat done pulse width", int'(done1), 0);

      // R4 R5 R6: several curves, points and scalars
      for (int c = 0; c < 3; c++) begin
         for (int j = 0; j < 3; j++) begin
            find_point(bvals[c], 11 * c + 23 * j + 3, px, py);
            run_one(px, bvals[c], kvals[(c + 2 * j) % 6], py, 1'b0);
         end
      end

      // R9: start during a run is ignored
      find_point(bvals[2], 40, px, py);
      run_one(px, bvals[2], 8'hD9, py, 1'b1);

      // R11: top scalar bit cleared gives the same result as set
      find_point(bvals[0], 60, px, py);
      run_one(px, bvals[0], 8'h25, py, 1'b0);

      // Back-to-back runs with random scalars
      for (int r = 0; r < 3; r++) begin
         logic [N-1:0] kr;
         kr = N'($urandom) | 8'h80;
         find_point(bvals[r], 70 + 5 * r, px, py);
         run_one(px, bvals[r], kr, py, 1'b0);
      end

      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule